// File: doc/BRIEF.md
# Watchdog Countdown Timer

This block is a 32-bit general-purpose down-counter that a host reads and writes as two 16-bit halves. Once running, it steps down by one on every tick of a fixed 5 MHz timebase. A prescaler produces that timebase by dividing the system clock. Two command strobes control it: one starts the counter and one halts it. When the count passes below zero, it reloads to all ones and keeps running. On that same event it sends a single-cycle completion pulse to an interrupt status register, which sits outside this block.

The host can load either half of the count at any time, whether the counter is running or halted. A load also restarts the prescaler, so the next step comes one full tick period after the write. Both halves are always visible as live outputs. After reset the counter is halted and holds zero.

Top module: `wdt_countdown_timer`

## Requirements
- R1: After reset, `halted` is 1, both count halves read 0 and `tc_pulse` is 0.
- R2: While running, the 32-bit count {`cnt_hi`,`cnt_lo`} drops by exactly one every DIV clock cycles (DIV = CLK_HZ / TICK_HZ, 20 by default). A borrow propagates from the low half into the high half.
- R3: A command write with `cmd_start` set clears `halted` from the next cycle. A command write with only `cmd_stop` set sets `halted`. A write with both set leaves the counter running. A write with neither bit set changes nothing.
- R4: While `halted` is 1, the count holds its value and `tc_pulse` stays 0, except when the host loads the count.
- R5: A step taken while the count is 0 loads 0xFFFFFFFF, the counter keeps running, and `tc_pulse` is high for exactly the one cycle in which the reloaded value first appears.
- R6: `cnt_lo` and `cnt_hi` always show the current count, one cycle after each update.
- R7: A write strobe for one half loads `cnt_wdata` into that half only and leaves the other half unchanged. If a write and a step fall in the same cycle, the write wins and the step is dropped.
- R8: Any count write restarts the prescaler. The first step after the write becomes visible DIV cycles after the written value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start request, valid with `cmd_wr` |
| cmd_stop | input | 1 | Halt request, valid with `cmd_wr` |
| cnt_wr_lo | input | 1 | Load the low half of the count |
| cnt_wr_hi | input | 1 | Load the high half of the count |
| cnt_wdata | input | HALF_W | Data for a count half load |
| cnt_lo | output | HALF_W | Live low half of the count |
| cnt_hi | output | HALF_W | Live high half of the count |
| halted | output | 1 | 1 while the counter is halted |
| tc_pulse | output | 1 | One-cycle underflow pulse to the status register |

## Verification
The bench times the first step after a start to the exact cycle. A prescaler that is off by one, or that keeps its phase across a halt, moves that step by one cycle and is caught. It drives the count through zero and checks both the all-ones reload and a pulse exactly one cycle wide. A design that stops at zero, or that holds the pulse high, fails there. A write to the low half that lands one step away from a borrow shows whether the borrow reaches the high half. A write placed on the exact cycle of a pending step shows whether the write takes priority and whether the prescaler restarts. The bench also sends a command with both bits set, which must leave the counter running, so a stop that wins over start is detected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    RUN_ACTIVE = 1'b0,
    RUN_HALTED = 1'b1
  } run_state_e;

  function automatic int unsigned div_ratio(input int unsigned clk_hz, input int unsigned tick_hz);
    return (clk_hz / tick_hz < 1) ? 1 : clk_hz / tick_hz;
  endfunction
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_direct
      assign tick_o = run_i && !restart_i;
    end else begin : g_divide
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      localparam logic [PW-1:0] STEP = PW'(1);
      logic [PW-1:0] phase_q;
      logic [PW-1:0] phase_d;
      logic          phase_en;

      always_comb begin
        phase_en = 1'b1;
        if (!run_i || restart_i)  phase_d = '0;
        else if (phase_q == LAST) phase_d = '0;
        else                      phase_d = phase_q + STEP;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        phase_q <= '0;
        else if (phase_en) phase_q <= phase_d;
      end

      assign tick_o = run_i && !restart_i && (phase_q == LAST);

      AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST) else $error("prescaler phase out of range"); // R2
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("ticks too close"); // R2
    end
  endgenerate
endmodule

// File: rtl/wdt_run_ctrl.sv
module wdt_run_ctrl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_start,
  input  logic cmd_stop,
  output logic halted_o
);
  run_state_e state_q;
  run_state_e state_d;
  logic       state_en;

  always_comb begin
    state_en = cmd_wr && (cmd_start || cmd_stop);
    if (cmd_start) state_d = RUN_ACTIVE;
    else           state_d = RUN_HALTED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RUN_HALTED;
    else if (state_en) state_q <= state_d;
  end

  assign halted_o = (state_q == RUN_HALTED);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_start) |=> !halted_o) else $error("start ignored"); // R3
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_stop && !cmd_start) |=> halted_o) else $error("stop ignored"); // R3
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [2*HALF_W-1:0] count_o,
  output logic              tc_o
);
  localparam int unsigned CW = 2 * HALF_W;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;
  logic          tc_q;
  logic          tc_d;

  always_comb begin
    count_d  = count_q;
    tc_d     = 1'b0;
    count_en = wr_lo_i || wr_hi_i || tick_i;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) count_d[HALF_W-1:0]  = wdata_i;
      if (wr_hi_i) count_d[CW-1:HALF_W] = wdata_i;
    end else if (tick_i) begin
      if (count_q == '0) begin
        count_d = '1;
        tc_d    = 1'b1;
      end else begin
        count_d = count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign count_o = count_q;
  assign tc_o    = tc_q;

  AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> (count_o == '1)) else $error("underflow did not reload ones"); // R5
  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o) else $error("tc pulse wider than one cycle"); // R5
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_lo_i && !wr_hi_i && count_o != '0) |=> (count_o == $past(count_o) - ONE))
    else $error("step not by one"); // R2
  AST_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !wr_hi_i) |=> (count_o[CW-1:HALF_W] == $past(count_o[CW-1:HALF_W])))
    else $error("low write disturbed high half"); // R7
endmodule

// File: rtl/wdt_countdown_timer.sv
module wdt_countdown_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 5_000_000,
  parameter int unsigned HALF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cnt_wr_lo,
  input  logic              cnt_wr_hi,
  input  logic [HALF_W-1:0] cnt_wdata,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              halted,
  output logic              tc_pulse
);
  localparam int unsigned DIV = div_ratio(CLK_HZ, TICK_HZ);
  localparam int unsigned CW  = 2 * HALF_W;

  logic          rst_s_n;
  logic          halted_w;
  logic          tick_w;
  logic          restart_w;
  logic [CW-1:0] count_w;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  wdt_run_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_wr    (cmd_wr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .halted_o  (halted_w)
  );

  assign restart_w = cnt_wr_lo || cnt_wr_hi;

  wdt_prescaler #(.DIV(DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run_i     (!halted_w),
    .restart_i (restart_w),
    .tick_o    (tick_w)
  );

  wdt_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick_i  (tick_w),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (cnt_wdata),
    .count_o (count_w),
    .tc_o    (tc_pulse)
  );

  assign cnt_lo = count_w[HALF_W-1:0];
  assign cnt_hi = count_w[CW-1:HALF_W];
  assign halted = halted_w;

  AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (halted_w && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(count_w))
    else $error("count moved while halted"); // R4
  AST_NO_TC_HALTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    halted_w |=> !tc_pulse) else $error("tc while halted"); // R4
endmodule

// File: tb/tb_wdt_countdown_timer.sv
module tb_wdt_countdown_timer;
  localparam int unsigned HALF_W = 16;

  logic              clk;
  logic              rst_n;
  logic              cmd_wr, cmd_start, cmd_stop;
  logic              cnt_wr_lo, cnt_wr_hi;
  logic [HALF_W-1:0] cnt_wdata;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              halted, tc_pulse;

  wdt_countdown_timer #(.CLK_HZ(100_000_000), .TICK_HZ(5_000_000), .HALF_W(HALF_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .cnt_wdata(cnt_wdata),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .halted(halted), .tc_pulse(tc_pulse)
  );

  typedef struct {
    int unsigned cyc;
    logic [31:0] cnt;
    logic        tc;
    logic        hlt;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int unsigned cyc;
  int          n_checks;
  int          n_fail;
  bit          finished;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int unsigned c, input logic [31:0] v, input logic tc,
                           input logic h, input string tag);
    exp_t e;
    e.cyc = c; e.cnt = v; e.tc = tc; e.hlt = h; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares outputs against queued expectations at the due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (e.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: check missed at cycle %0d (now %0d)", e.tag, e.cyc, cyc);
      end else if ({cnt_hi, cnt_lo} !== e.cnt || tc_pulse !== e.tc || halted !== e.hlt) begin
        n_fail++;
        $display("FAIL %s: cyc %0d count=%h tc=%b halted=%b expected count=%h tc=%b halted=%b",
                 e.tag, cyc, {cnt_hi, cnt_lo}, tc_pulse, halted, e.cnt, e.tc, e.hlt);
      end
    end
  end

  task automatic drive_cmd(input logic st, input logic sp);
    cmd_wr = 1'b1; cmd_start = st; cmd_stop = sp;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  task automatic drive_wr(input logic lo, input logic hi, input logic [HALF_W-1:0] d);
    cnt_wr_lo = lo; cnt_wr_hi = hi; cnt_wdata = d;
    @(negedge clk);
    cnt_wr_lo = 1'b0; cnt_wr_hi = 1'b0; cnt_wdata = '0;
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int unsigned a, s, u, w;
    cyc = 0; n_checks = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; cmd_wr = 0; cmd_start = 0; cmd_stop = 0;
    cnt_wr_lo = 0; cnt_wr_hi = 0; cnt_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    expect_at(cyc + 1, 32'h0, 1'b0, 1'b1, "R1 reset");
    repeat (2) @(negedge clk);

    // R7 half writes while halted, R4 hold, R3 empty command
    a = cyc;
    expect_at(a + 1, 32'h0000_0005, 1'b0, 1'b1, "R7 low write");
    expect_at(a + 2, 32'h00AB_0005, 1'b0, 1'b1, "R7 high write keeps low");
    expect_at(a + 3, 32'h0000_0005, 1'b0, 1'b1, "R7 high write");
    expect_at(a + 5, 32'h0000_0005, 1'b0, 1'b1, "R3 empty command no effect");
    expect_at(a + 100, 32'h0000_0005, 1'b0, 1'b1, "R4 halted hold");
    drive_wr(1'b1, 1'b0, 16'h0005);
    drive_wr(1'b0, 1'b1, 16'h00AB);
    drive_wr(1'b0, 1'b1, 16'h0000);
    drive_cmd(1'b0, 1'b0);
    wait_until(a + 110);

    // R2/R3/R5/R6 start and count through underflow
    s = cyc;
    expect_at(s + 1,   32'h0000_0005, 1'b0, 1'b0, "R3 start clears halted");
    expect_at(s + 20,  32'h0000_0005, 1'b0, 1'b0, "R2 no early step");
    expect_at(s + 21,  32'h0000_0004, 1'b0, 1'b0, "R2 first step");
    expect_at(s + 101, 32'h0000_0000, 1'b0, 1'b0, "R6 live count zero");
    expect_at(s + 120, 32'h0000_0000, 1'b0, 1'b0, "R5 before underflow");
    expect_at(s + 121, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5 reload and pulse");
    expect_at(s + 122, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 pulse one cycle");
    expect_at(s + 141, 32'hFFFF_FFFE, 1'b0, 1'b0, "R5 keeps running");
    drive_cmd(1'b1, 1'b0);
    wait_until(s + 150);
    expect_at(s + 151, 32'hFFFF_FFFE, 1'b0, 1'b1, "R3 stop halts");
    expect_at(s + 250, 32'hFFFF_FFFE, 1'b0, 1'b1, "R4 halted no step");
    drive_cmd(1'b0, 1'b1);
    wait_until(s + 260);

    // R7/R8 writes while running, borrow across halves
    u = cyc;
    expect_at(u + 20, 32'hFFFF_FFFE, 1'b0, 1'b0, "R2 restart phase from zero");
    expect_at(u + 21, 32'hFFFF_FFFD, 1'b0, 1'b0, "R2 step after restart");
    expect_at(u + 31, 32'h0001_FFFD, 1'b0, 1'b0, "R7 high write running");
    expect_at(u + 50, 32'h0001_FFFD, 1'b0, 1'b0, "R8 prescaler restarted");
    expect_at(u + 51, 32'h0001_FFFC, 1'b0, 1'b0, "R8 step after write");
    expect_at(u + 61, 32'h0001_0000, 1'b0, 1'b0, "R7 low write running");
    expect_at(u + 81, 32'h0000_FFFF, 1'b0, 1'b0, "R2 borrow into high half");
    expect_at(u + 91, 32'h0000_FFFF, 1'b0, 1'b1, "R3 stop again");
    drive_cmd(1'b1, 1'b0);
    wait_until(u + 30);
    drive_wr(1'b0, 1'b1, 16'h0001);
    wait_until(u + 60);
    drive_wr(1'b1, 1'b0, 16'h0000);
    wait_until(u + 90);
    drive_cmd(1'b0, 1'b1);
    wait_until(u + 120);

    // R3 both bits, R7 write beats a coincident step
    w = cyc;
    expect_at(w + 1,  32'h0000_FFFF, 1'b0, 1'b0, "R3 both bits run");
    expect_at(w + 20, 32'h0000_FFFF, 1'b0, 1'b0, "R2 step timing");
    expect_at(w + 21, 32'h0000_FFFE, 1'b0, 1'b0, "R2 step");
    expect_at(w + 41, 32'h0000_1234, 1'b0, 1'b0, "R7 write wins over step");
    expect_at(w + 60, 32'h0000_1234, 1'b0, 1'b0, "R8 full period after write");
    expect_at(w + 61, 32'h0000_1233, 1'b0, 1'b0, "R8 step after write");
    drive_cmd(1'b1, 1'b1);
    wait_until(w + 40);
    drive_wr(1'b1, 1'b0, 16'h1234);
    wait_until(w + 70);

    while (sbq.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule